// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit down counters behind a byte-wide register port. Data ports 0, 1 and 2 reach the count registers of channels 0, 1 and 2. Port 3 is a shared command port. A byte written there either reprograms one channel (its byte-access scheme, its counting mode and its number system) or freezes a snapshot of that channel's count for reading. Software then loads an initial count through the channel's data port as one or two bytes. It reads the count back either live or from the frozen snapshot.

Counting advances on a shared count-tick enable, which is one system clock wide. Each channel also has a gate input and an output line. With six modes, a channel can act as a terminal-count flag, a retriggerable one-shot, a rate generator, a square-wave generator, or a strobe fired by software or by the gate. A channel loaded with count N divides the tick rate by N. Binary counting spans 1..65536 and BCD counting spans 1..10000, with a loaded zero standing for the largest value.

Top module: `triTimer`

## Requirements
- R1: After reset every output is low, every count reads 0, and every channel is in mode 0 with binary counting and low-then-high byte access.
- R2: A command byte carries the channel in bits 7:6 (00, 01 and 10 pick channels 0..2; 11 is ignored), the access type in bits 5:4, the mode in bits 3:1 (110 and 111 act as 010 and 011), and BCD in bit 0. A command with a non-zero access type sets the channel's output to its initial level (low in mode 0, high otherwise), stops counting and resets the byte pointer.
- R3: Access type 01 moves only the low byte and 10 moves only the high byte; the other byte is zero when written. Type 11 moves the low byte and then the high byte, with a per-channel pointer that toggles on each data-port access. Reads without a latch return the live count.
- R4: A fully written count is loaded into the counter on the next count tick, whatever the gate level. A count of zero behaves as 65536 in binary or 10000 in BCD.
- R5: Access type 00 copies the live count into a hold register, and reads return it while counting goes on. The copy is kept until it has been fully read (both bytes for type 11). Latch commands are ignored while a copy is held. A latch does not change the mode or the access type.
- R6: In BCD mode the counter decrements across four decimal digits (0x0100 goes to 0x0099, and 0x0000 goes to 0x9999).
- R7: Mode 0: the output is low after loading and goes high on the N-th decrement, then stays high.
- R8: Mode 1: the output stays high until a gate rising edge. The tick that takes the trigger loads the count and drives the output low for N ticks; a new trigger restarts the count.
- R9: Mode 2: the output is low for one tick in every N ticks and high otherwise, and the counter reloads by itself.
- R10: Mode 3: the output is high for ceil(N/2) ticks and low for floor(N/2) ticks of each N-tick period.
- R11: Mode 4: N ticks after the load, the output drops low for exactly one tick, once.
- R12: Mode 5: counting starts on a gate rising edge. N ticks after the trigger tick, the output drops low for exactly one tick, once per trigger.
- R13: A low gate pauses decrementing in modes 0, 2, 3 and 4. In modes 2 and 3 a low gate forces the output high, and a gate rising edge restarts the count from its loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for the register port |
| rd | input | 1 | Read strobe, one cycle per byte |
| wr | input | 1 | Write strobe, one cycle per byte |
| addr | input | 2 | Port offset: 0..2 data of a channel, 3 command |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte (combinational, zero when not reading a data port) |
| cntTick | input | 1 | Count clock enable shared by all channels |
| gate | input | 3 | Gate input of each channel |
| timerOut | output | 3 | Output line of each channel |

## Verification
Square-wave and rate-generator periods are measured over two full periods for random counts, with odd and even N mixed. Odd counts show whether the extra high tick sits on the right side, and the low-tick total shows whether the reload is early or late. Random 16-bit counts are read back through the latch in both byte orders, which tells a byte swap or a stuck pointer from a correct load. Directed runs cover zero counts in both number systems, BCD borrows, and pauses and retriggers from the gate. They also cover a second latch issued while a copy is held, the pointer reset by a command, the mode aliases, and a command aimed at the unused channel code.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
  localparam int NCH   = 3;
  localparam int CNT_W = 16;
  localparam int BYTE_W = 8;
  localparam int DIGITS = CNT_W / 4;
  localparam logic [1:0] CMD_ADDR = 2'd3;

  typedef enum logic [1:0] {ACC_LATCH = 2'd0, ACC_LO = 2'd1, ACC_HI = 2'd2, ACC_LOHI = 2'd3} acc_t;

  localparam logic [2:0] M_TC = 3'd0, M_ONESHOT = 3'd1, M_RATE = 3'd2,
                         M_SQUARE = 3'd3, M_SWSTB = 3'd4, M_HWSTB = 3'd5;

  typedef struct packed {
    logic ctlWr;
    logic latch;
    logic dataWr;
    logic dataRd;
  } chanStrobe_t;

  function automatic logic [2:0] aliasMode(input logic [2:0] m);
    return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
  endfunction

  function automatic logic [CNT_W-1:0] decCount(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    if (!bcd) r = v - 1'b1;
    else begin
      for (int d = 0; d < DIGITS; d++) begin
        if (borrow) begin
          if (v[4*d +: 4] == 4'd0) r[4*d +: 4] = 4'd9;
          else begin
            r[4*d +: 4] = v[4*d +: 4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] halfCount(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic carry;
    r = '0;
    carry = 1'b0;
    if (!bcd) r = v >> 1;
    else begin
      for (int d = DIGITS - 1; d >= 0; d--) begin
        r[4*d +: 4] = {1'b0, v[4*d+1 +: 3]} + (carry ? 4'd5 : 4'd0);
        carry = v[4*d];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pitCtrl.sv
`timescale 1ns/1ps
module pitCtrl import pit_pkg::*; (
  input  logic        cs,
  input  logic        wr,
  input  logic        rd,
  input  logic [1:0]  addr,
  input  logic [3:0]  cmdHi,
  output chanStrobe_t [NCH-1:0] strb
);
  logic cmdHit;
  assign cmdHit = cs && wr && (addr == CMD_ADDR);

  for (genvar i = 0; i < NCH; i++) begin : g_route
    logic portHit, selHit;
    assign portHit = cs && (addr == 2'(i));
    assign selHit  = cmdHit && (cmdHi[3:2] == 2'(i));
    assign strb[i].dataWr = portHit && wr;
    assign strb[i].dataRd = portHit && rd;
    assign strb[i].ctlWr  = selHit && (cmdHi[1:0] != ACC_LATCH);
    assign strb[i].latch  = selHit && (cmdHi[1:0] == ACC_LATCH);
  end
endmodule

// File: rtl/pitChannel.sv
`timescale 1ns/1ps
module pitChannel import pit_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobe_t       strb,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              tick,
  input  logic              gate,
  output logic [BYTE_W-1:0] rbyte,
  output logic              out
);
  logic [2:0]        modeQ;
  acc_t              accQ;
  logic              bcdQ, ptrQ, latchedQ, runQ, pendQ, loadedQ, firedQ, trigQ, gatePrevQ, outQ;
  logic [BYTE_W-1:0] lowQ;
  logic [CNT_W-1:0]  crQ, ceQ, latchQ;

  logic [CNT_W-1:0] nxt, halfVal, readSrc;
  logic isTrig, isPer, sqHigh, wrDone, ceOne;

  assign ceOne   = (ceQ == CNT_W'(1));
  assign isTrig  = (modeQ == M_ONESHOT) || (modeQ == M_HWSTB);
  assign isPer   = (modeQ == M_RATE) || (modeQ == M_SQUARE);
  assign nxt     = ceOne ? crQ : decCount(ceQ, bcdQ);
  assign halfVal = (crQ == '0) ? (bcdQ ? CNT_W'(16'h5000) : CNT_W'(16'h8000)) : halfCount(crQ, bcdQ);
  assign sqHigh  = (nxt == '0) || (nxt > halfVal);
  assign wrDone  = strb.dataWr && ((accQ != ACC_LOHI) || ptrQ);
  assign readSrc = latchedQ ? latchQ : ceQ;
  assign out     = outQ;

  always_comb begin
    case (accQ)
      ACC_LO:  rbyte = readSrc[BYTE_W-1:0];
      ACC_HI:  rbyte = readSrc[CNT_W-1:BYTE_W];
      default: rbyte = ptrQ ? readSrc[CNT_W-1:BYTE_W] : readSrc[BYTE_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= M_TC; accQ <= ACC_LOHI; bcdQ <= 1'b0; ptrQ <= 1'b0;
      latchedQ <= 1'b0; runQ <= 1'b0; pendQ <= 1'b0; loadedQ <= 1'b0;
      firedQ <= 1'b0; trigQ <= 1'b0; gatePrevQ <= 1'b0; outQ <= 1'b0;
      lowQ <= '0; crQ <= '0; ceQ <= '0; latchQ <= '0;
    end else begin
      gatePrevQ <= gate;
      if (strb.ctlWr) begin
        modeQ <= aliasMode(wbyte[3:1]);
        accQ <= acc_t'(wbyte[5:4]);
        bcdQ <= wbyte[0];
        ptrQ <= 1'b0; runQ <= 1'b0; pendQ <= 1'b0; loadedQ <= 1'b0;
        firedQ <= 1'b0; trigQ <= 1'b0; latchedQ <= 1'b0;
        outQ <= (wbyte[3:1] != M_TC);
      end else begin
        if (tick) begin
          trigQ <= 1'b0;
          if (pendQ) begin
            ceQ <= crQ; pendQ <= 1'b0; runQ <= 1'b0 | 1'b1; firedQ <= 1'b0;
            outQ <= (modeQ != M_TC);
          end else if (trigQ && ((isTrig && loadedQ) || (isPer && runQ))) begin
            ceQ <= crQ; runQ <= 1'b1; firedQ <= 1'b0;
            outQ <= (modeQ != M_ONESHOT);
          end else if (runQ) begin
            case (modeQ)
              M_TC, M_ONESHOT: if (gate || modeQ == M_ONESHOT) begin
                ceQ <= decCount(ceQ, bcdQ);
                if (ceOne) outQ <= 1'b1;
              end
              M_RATE, M_SQUARE: if (gate) begin
                ceQ <= nxt;
                outQ <= (modeQ == M_RATE) ? (nxt != CNT_W'(1)) : sqHigh;
              end else outQ <= 1'b1;
              default: if (gate || modeQ == M_HWSTB) begin
                ceQ <= decCount(ceQ, bcdQ);
                outQ <= !(ceOne && !firedQ);
                if (ceOne) firedQ <= 1'b1;
              end
            endcase
          end
        end
        if (strb.dataWr) begin
          case (accQ)
            ACC_LO: crQ <= {{(CNT_W-BYTE_W){1'b0}}, wbyte};
            ACC_HI: crQ <= {wbyte, {(CNT_W-BYTE_W){1'b0}}};
            default: begin
              if (!ptrQ) lowQ <= wbyte;
              else crQ <= {wbyte, lowQ};
              ptrQ <= !ptrQ;
            end
          endcase
          if (wrDone) begin
            loadedQ <= 1'b1;
            if (!isTrig) pendQ <= 1'b1;
          end
        end
        if (strb.dataRd) begin
          if (accQ == ACC_LOHI) ptrQ <= !ptrQ;
          if (latchedQ && ((accQ != ACC_LOHI) || ptrQ)) latchedQ <= 1'b0;
        end
        if (strb.latch && !latchedQ) begin
          latchQ <= ceQ;
          latchedQ <= 1'b1;
        end
      end
      if (gate && !gatePrevQ) trigQ <= 1'b1;
    end
  end

  // R2: a command drives the output to the initial level of the requested mode
  assert_ctl_init_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctlWr |=> (outQ == ($past(wbyte[3:1]) != M_TC)));
  // R4: the output moves only on a count tick or a command
  assert_out_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strb.ctlWr) |=> $stable(outQ));
  // R5: a held snapshot is not overwritten until it is read out
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (latchedQ && !strb.ctlWr && !strb.dataRd) |=> ($stable(latchQ) && latchedQ));
  // R9: the rate generator low phase lasts one tick
  assert_rate_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tick && modeQ == M_RATE && !outQ && !strb.ctlWr && crQ != CNT_W'(1)) |=> outQ);
  // R7: once high after terminal count, mode 0 stays high until reload
  assert_tc_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && modeQ == M_TC && outQ && !pendQ && !strb.ctlWr && !wrDone) |=> outQ);
endmodule

// File: rtl/triTimer.sv
`timescale 1ns/1ps
module triTimer import pit_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              cntTick,
  input  logic [NCH-1:0]    gate,
  output logic [NCH-1:0]    timerOut
);
  chanStrobe_t [NCH-1:0] strb;
  logic [BYTE_W-1:0] chanByte [NCH];

  pitCtrl u_ctrl (
    .cs(cs), .wr(wr), .rd(rd), .addr(addr), .cmdHi(wdata[7:4]), .strb(strb)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    pitChannel u_chan (
      .clk(clk), .rstN(rstN), .strb(strb[i]), .wbyte(wdata), .tick(cntTick),
      .gate(gate[i]), .rbyte(chanByte[i]), .out(timerOut[i])
    );
  end

  always_comb begin
    rdata = '0;
    if (cs && rd)
      for (int i = 0; i < NCH; i++)
        if (addr == 2'(i)) rdata = chanByte[i];
  end
endmodule

// File: tb/sim_triTimer.sv
`timescale 1ns/1ps
module sim_triTimer;
  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, rd = 1'b0, wr = 1'b0, cntTick = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [2:0] gate = 3'b111, timerOut;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  triTimer u0 (.clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
               .wdata(wdata), .rdata(rdata), .cntTick(cntTick), .gate(gate), .timerOut(timerOut));

  function automatic logic [7:0] cmd(input int ch, input int acc, input int mode, input int bcd);
    return {2'(ch), 2'(acc), 3'(mode), 1'(bcd)};
  endfunction
  function automatic int sqHighTicks(input int n); return 2 * ((n + 1) / 2); endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask
  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask
  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask
  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cntTick = 1;
      @(negedge clk); cntTick = 0;
    end
  endtask
  task automatic pulseGate(input int ch);
    @(negedge clk); gate[ch] = 0;
    @(negedge clk); gate[ch] = 1;
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo, hi;
    int n, cnt, seed;
    seed = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 outputs", timerOut, 0);
    rdReg(0, lo); rdReg(0, hi);
    chk("R1 count", {hi, lo}, 0);

    // R7 mode 0 with count 5
    wrReg(3, cmd(0, 3, 0, 0));
    chk("R2 mode0 init low", timerOut[0], 0);
    wrReg(0, 8'd5); wrReg(0, 8'd0);
    step(5); chk("R7 before terminal", timerOut[0], 0);
    step(1); chk("R7 at terminal", timerOut[0], 1);
    step(3); chk("R7 stays high", timerOut[0], 1);

    // R13 gate pause, R4 load independent of gate
    gate[1] = 0;
    wrReg(3, cmd(1, 3, 0, 0));
    wrReg(1, 8'd7); wrReg(1, 8'd0);
    step(10); chk("R13 paused output", timerOut[1], 0);
    wrReg(3, cmd(1, 0, 0, 0));
    rdReg(1, lo); rdReg(1, hi);
    chk("R13 paused count", {hi, lo}, 7);
    gate[1] = 1;

    // R5 latch hold and ignored second latch, mode 2 channel 2
    wrReg(3, cmd(2, 3, 2, 0));
    chk("R2 mode2 init high", timerOut[2], 1);
    wrReg(2, 8'd10); wrReg(2, 8'd0);
    step(1); step(3);
    wrReg(3, cmd(2, 0, 0, 0));
    step(2);
    wrReg(3, cmd(2, 0, 0, 0));
    rdReg(2, lo); rdReg(2, hi);
    chk("R5 first snapshot kept", {hi, lo}, 7);
    wrReg(3, cmd(2, 0, 0, 0));
    rdReg(2, lo); rdReg(2, hi);
    chk("R5 fresh snapshot", {hi, lo}, 5);

    // R9 rate generator: two lows per 2N ticks
    for (int t = 0; t < 4; t++) begin
      n = 3 + ($urandom % 18);
      wrReg(2, 8'(n)); wrReg(2, 8'd0);
      step(1);
      cnt = 0;
      for (int k = 0; k < 2 * n; k++) begin step(1); if (!timerOut[2]) cnt++; end
      chk($sformatf("R9 lows n=%0d", n), cnt, 2);
    end

    // R10 square wave, directed 5 and 6 then random
    wrReg(3, cmd(0, 3, 3, 0));
    for (int t = 0; t < 6; t++) begin
      n = (t == 0) ? 5 : (t == 1) ? 6 : 2 + ($urandom % 20);
      wrReg(0, 8'(n)); wrReg(0, 8'd0);
      step(1);
      cnt = 0;
      for (int k = 0; k < 2 * n; k++) begin step(1); if (timerOut[0]) cnt++; end
      chk($sformatf("R10 high ticks n=%0d", n), cnt, sqHighTicks(n));
    end
    step(2);
    gate[0] = 0; step(1);
    chk("R13 gate low forces high", timerOut[0], 1);
    gate[0] = 1;

    // R8 retriggerable one-shot on channel 1
    wrReg(3, cmd(1, 3, 1, 0));
    wrReg(1, 8'd3); wrReg(1, 8'd0);
    step(2); chk("R8 idle without trigger", timerOut[1], 1);
    pulseGate(1);
    step(1); chk("R8 low on trigger", timerOut[1], 0);
    pulseGate(1);
    step(1); step(2); chk("R8 retrigger extends low", timerOut[1], 0);
    step(1); chk("R8 ends high", timerOut[1], 1);

    // R12 gate-triggered strobe
    wrReg(3, cmd(1, 3, 5, 0));
    wrReg(1, 8'd4); wrReg(1, 8'd0);
    step(3); chk("R12 idle without trigger", timerOut[1], 1);
    pulseGate(1);
    step(4); chk("R12 before strobe", timerOut[1], 1);
    step(1); chk("R12 strobe low", timerOut[1], 0);
    step(1); chk("R12 strobe one tick", timerOut[1], 1);
    step(10); chk("R12 strobe once", timerOut[1], 1);

    // R11 software strobe
    wrReg(3, cmd(2, 3, 4, 0));
    wrReg(2, 8'd3); wrReg(2, 8'd0);
    step(3); chk("R11 before strobe", timerOut[2], 1);
    step(1); chk("R11 strobe low", timerOut[2], 0);
    step(1); chk("R11 strobe one tick", timerOut[2], 1);

    // R6 BCD decrement and R4 zero count
    wrReg(3, cmd(0, 3, 0, 1));
    wrReg(0, 8'h00); wrReg(0, 8'h01);
    step(2);
    wrReg(3, cmd(0, 0, 0, 0));
    rdReg(0, lo); rdReg(0, hi);
    chk("R6 bcd borrow", {hi, lo}, 16'h0099);
    wrReg(3, cmd(0, 3, 0, 1));
    wrReg(0, 8'h00); wrReg(0, 8'h00);
    step(2);
    wrReg(3, cmd(0, 0, 0, 0));
    rdReg(0, lo); rdReg(0, hi);
    chk("R4 bcd zero is max", {hi, lo}, 16'h9999);
    wrReg(3, cmd(0, 3, 0, 0));
    wrReg(0, 8'h00); wrReg(0, 8'h00);
    step(2);
    wrReg(3, cmd(0, 0, 0, 0));
    rdReg(0, lo); rdReg(0, hi);
    chk("R4 binary zero is max", {hi, lo}, 16'hFFFF);

    // R4 random count readback, gate low so no decrement
    gate[1] = 0;
    wrReg(3, cmd(1, 3, 0, 0));
    for (int t = 0; t < 6; t++) begin
      n = int'($urandom % 65536);
      wrReg(1, 8'(n)); wrReg(1, 8'(n >> 8));
      step(1);
      wrReg(3, cmd(1, 0, 0, 0));
      rdReg(1, lo); rdReg(1, hi);
      chk("R4 random load", {hi, lo}, n);
    end
    gate[1] = 1;

    // R3 access types, R5 latch keeps access type
    wrReg(3, cmd(2, 1, 0, 0));
    wrReg(2, 8'h23); step(1);
    wrReg(3, cmd(2, 0, 0, 0));
    rdReg(2, lo); chk("R3 low-only", lo, 8'h23);
    step(1);
    wrReg(3, cmd(2, 0, 0, 0));
    rdReg(2, lo); chk("R5 latch keeps access", lo, 8'h22);
    wrReg(3, cmd(2, 2, 0, 0));
    wrReg(2, 8'h12); step(1);
    wrReg(3, cmd(2, 0, 0, 0));
    rdReg(2, hi); chk("R3 high-only", hi, 8'h12);
    wrReg(3, cmd(2, 3, 0, 0));
    wrReg(2, 8'h55);
    wrReg(3, cmd(2, 3, 0, 0));
    wrReg(2, 8'h34); wrReg(2, 8'h12);
    step(1);
    wrReg(3, cmd(2, 0, 0, 0));
    rdReg(2, lo); rdReg(2, hi);
    chk("R2 pointer reset", {hi, lo}, 16'h1234);
    step(1);
    rdReg(2, lo); rdReg(2, hi);
    chk("R3 live read", {hi, lo}, 16'h1233);

    // R2 mode alias 110 -> rate generator
    wrReg(3, cmd(0, 3, 6, 0));
    wrReg(0, 8'd3); wrReg(0, 8'd0);
    step(2); chk("R2 alias low pulse", timerOut[0], 1);
    step(1); chk("R2 alias rate low", timerOut[0], 0);

    // R2 unused channel code
    wrReg(3, cmd(0, 3, 3, 0)); wrReg(3, cmd(1, 3, 3, 0)); wrReg(3, cmd(2, 3, 3, 0));
    chk("R2 all high", timerOut, 7);
    wrReg(3, 8'hC0);
    chk("R2 channel code 11 ignored", timerOut, 7);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule